// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block controls a byte-wide memory in which every location has two copies: a working SRAM byte that the host reads and writes, and a nonvolatile shadow byte that keeps its value across a power cycle. The host reaches the SRAM through active-low chip-select, write and output-enable strobes, an address and a split data bus. The controller copies the whole SRAM into the shadow (store) and the whole shadow back into SRAM (recall). It also decides when host writes and reads may reach the array.

A recall runs by itself after every reset, which models power-up. A store can start in two ways. The first is the rising edge of a digital supply-low flag from an external comparator. The second is an external low pulse on a shared open-drain busy line. The controller pulls that busy line low for the whole store. An automatic store is abandoned if the line still reads high at the end of the initial pull-down pulse. While the supply flag is low, host writes and externally requested stores are refused. After a recall or a store, a write strobe that was already active is ignored until a new falling edge appears on chip-select or write. The durations of the store, the recall, the pull-down pulse, the wait for a current access to finish and the recovery time are all parameters counted in clock cycles.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset is released, a recall runs for RECALL_CYC clock edges. During the recall the read bus stays released and the busy line is not pulled. After it, every SRAM byte equals the shadow byte at the same address.
- R2: With cs_n=0 and wr_n=0 the byte on wdata is written at addr. With cs_n=0, oe_n=0 and wr_n=1, rdata carries the byte at addr and rdata_en=1. Otherwise rdata_en=0.
- R3: When sb_line reads low for REQ_MIN consecutive clock edges in the idle state, a hardware store is requested. sb_pull rises at the REQ_MIN-th edge if cs_n is high.
- R4: A started store keeps sb_pull=1 for exactly PULSE_CYC+STORE_CYC cycles. During that time rdata_en stays 0. At the end the whole SRAM is copied into the shadow.
- R5: After a hardware store releases the line, host access stays blocked (rdata_en=0) for RECOVER_CYC cycles. Access opens on the next edge.
- R6: A rising pwr_low in the idle state starts an automatic store at the next edge. Only one attempt is made for each low-supply episode, and the flag must go high again before another is armed.
- R7: While pwr_low=1, host writes leave the SRAM unchanged and busy-line pulses start no store. Reads still work.
- R8: If sb_line reads high in the last cycle of the pull-down pulse of an automatic store, the controller releases the line after PULSE_CYC cycles. The shadow is left unchanged.
- R9: If cs_n and wr_n are both low when a recall or a store ends, writes are ignored until a falling edge is seen on cs_n or wr_n.
- R10: If cs_n is low when a store is requested, the pull-down waits until cs_n goes high or DRAIN_CYC cycles have passed, whichever comes first.
- R11: A busy-line pulse that arrives while a store is running does not start a second store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| rdata_en | output | 1 | Read data drive enable |
| pwr_low | input | 1 | Supply-low flag from the comparator |
| sb_line | input | 1 | Level sensed on the shared busy line |
| sb_pull | output | 1 | Pulls the busy line low when 1 |

## Verification
Read data is combinational from the address and the state, so read results are sampled 1 ns after the falling edge at which the strobes are applied. A busy-line request shows on sb_pull after the REQ_MIN-th rising edge of the low level. When a read or write is in progress at that moment, it shows DRAIN_CYC edges later. A supply-low request shows after the first edge. The bench counts falling edges to measure the busy window, which must be PULSE_CYC+STORE_CYC long, or PULSE_CYC long for an aborted attempt. It then checks that access stays closed for the RECOVER_CYC recovery edges and opens on the edge after them. The shadow contents are checked through a second reset and recall, after which the stored bytes are read back.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int AW          = 11,
  parameter int DW          = 8,
  parameter int RECALL_CYC  = 55000,
  parameter int STORE_CYC   = 1000000,
  parameter int PULSE_CYC   = 2,
  parameter int REQ_MIN     = 2,
  parameter int DRAIN_CYC   = 100,
  parameter int RECOVER_CYC = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_en,
  input  logic          pwr_low,
  input  logic          sb_line,
  output logic          sb_pull
);
  localparam int DEPTH = 1 << AW;
  localparam int M1 = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
  localparam int M2 = (DRAIN_CYC > RECOVER_CYC) ? DRAIN_CYC : RECOVER_CYC;
  localparam int M3 = (PULSE_CYC > REQ_MIN) ? PULSE_CYC : REQ_MIN;
  localparam int M4 = (M2 > M3) ? M2 : M3;
  localparam int MAXC = (M1 > M4) ? M1 : M4;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_RECALL, S_IDLE, S_DRAIN, S_PULSE, S_STORE, S_RECOVER
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt, lowcnt;
  logic           wlock, auto_src, armed, cs_q, wr_q;
  logic [DW-1:0]  sram [DEPTH];
  logic [DW-1:0]  nv   [DEPTH];

  wire idle      = (st == S_IDLE);
  wire open_acc  = idle | (st == S_DRAIN);
  wire last      = (cnt == '0);
  wire edge_seen = (cs_q & ~cs_n) | (wr_q & ~wr_n);
  wire wr_go     = open_acc & ~pwr_low & ~cs_n & ~wr_n & (~wlock | edge_seen);
  wire auto_go   = idle & pwr_low & armed;
  wire hw_go     = idle & ~pwr_low & ~sb_line & (lowcnt == CW'(REQ_MIN - 1));
  wire copy_out  = (st == S_STORE) & last;
  wire copy_in   = (st == S_RECALL) & last;

  assign sb_pull  = (st == S_PULSE) | (st == S_STORE);
  assign rdata_en = open_acc & ~cs_n & ~oe_n & wr_n;
  assign rdata    = sram[addr];

  always_ff @(posedge clk) begin
    if (copy_in) sram <= nv;
    else if (wr_go) sram[addr] <= wdata;
    if (copy_out) nv <= sram;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RECALL;
      cnt      <= CW'(RECALL_CYC - 1);
      lowcnt   <= '0;
      wlock    <= 1'b1;
      auto_src <= 1'b0;
      armed    <= 1'b0;
      cs_q     <= 1'b1;
      wr_q     <= 1'b1;
    end else begin
      cs_q <= cs_n;
      wr_q <= wr_n;

      if (sb_line) lowcnt <= '0;
      else if (!idle) lowcnt <= CW'(REQ_MIN);
      else if (lowcnt < CW'(REQ_MIN)) lowcnt <= lowcnt + CW'(1);

      if (!pwr_low) armed <= 1'b1;
      else if (!idle || auto_go) armed <= 1'b0;

      if (edge_seen) wlock <= 1'b0;

      case (st)
        S_RECALL:
          if (last) begin
            st    <= S_IDLE;
            wlock <= 1'b1;
          end else cnt <= cnt - CW'(1);
        S_IDLE:
          if (auto_go || hw_go) begin
            auto_src <= auto_go;
            if (cs_n) begin
              st  <= S_PULSE;
              cnt <= CW'(PULSE_CYC - 1);
            end else begin
              st  <= S_DRAIN;
              cnt <= CW'(DRAIN_CYC - 1);
            end
          end
        S_DRAIN:
          if (cs_n || last) begin
            st  <= S_PULSE;
            cnt <= CW'(PULSE_CYC - 1);
          end else cnt <= cnt - CW'(1);
        S_PULSE:
          if (last) begin
            if (auto_src && sb_line) st <= S_IDLE;
            else begin
              st  <= S_STORE;
              cnt <= CW'(STORE_CYC - 1);
            end
          end else cnt <= cnt - CW'(1);
        S_STORE:
          if (last) begin
            wlock <= 1'b1;
            if (auto_src) st <= S_IDLE;
            else begin
              st  <= S_RECOVER;
              cnt <= CW'(RECOVER_CYC - 1);
            end
          end else cnt <= cnt - CW'(1);
        S_RECOVER:
          if (last) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_recall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECALL) |-> (!rdata_en && !sb_pull));

  a_r4_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    sb_pull |-> !rdata_en);

  a_r5_hw_store_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_out && !auto_src) |=> (st == S_RECOVER));

  a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PULSE) && last && auto_src && sb_line) |=> (st == S_IDLE));

  a_r9_lock_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    copy_out |=> wlock);

  a_r11_store_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE) |=> (st == S_STORE || st == S_RECOVER || st == S_IDLE));

  a_r7_no_store_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_low && !armed) |=> !sb_pull);

endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
  localparam int AW = 11, DW = 8;
  localparam int RECALL = 20, STORE = 30, PULSE = 3, REQ = 2, DRAIN = 4, RECOV = 5;
  localparam logic [18:0] VEC [8] = '{
    {11'h000, 8'h5A}, {11'h001, 8'hA5}, {11'h7FF, 8'h3C}, {11'h400, 8'hC3},
    {11'h0AA, 8'h11}, {11'h555, 8'hEE}, {11'h123, 8'h96}, {11'h3C0, 8'h0F}};
  localparam logic [AW-1:0] A_ADR = 11'h010, B_ADR = 11'h020;

  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, oe_n = 1, pwr_low = 0;
  logic ext_low = 0, stuck_hi = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_en, sb_pull;
  wire  sb_line = stuck_hi ? 1'b1 : ~(sb_pull | ext_low);
  int   nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  nvsram_ctrl #(.AW(AW), .DW(DW), .RECALL_CYC(RECALL), .STORE_CYC(STORE),
    .PULSE_CYC(PULSE), .REQ_MIN(REQ), .DRAIN_CYC(DRAIN), .RECOVER_CYC(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .pwr_low(pwr_low),
    .sb_line(sb_line), .sb_pull(sb_pull));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; cs_n = 0; wr_n = 0;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); addr = a; cs_n = 0; oe_n = 0;
    #1;
    chk({tag, " read enable"}, int'(rdata_en), 1);
    chk({tag, " read data"}, int'(rdata), int'(exp));
    @(negedge clk); cs_n = 1; oe_n = 1;
  endtask

  task automatic count_busy(inout int n);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!sb_pull) break;
      n++;
      chk("R4 no read while busy", int'(rdata_en), 0);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state and recall length
    cs_n = 0; oe_n = 0;
    #1;
    chk("R1 bus released in reset", int'(rdata_en), 0);
    chk("R1 line free in reset", int'(sb_pull), 0);
    @(negedge clk); rst_n = 1;
    for (int k = 1; k <= RECALL; k++) begin
      @(negedge clk);
      if (k < RECALL) chk("R1 blocked during recall", int'(rdata_en), 0);
      else chk("R1 access opens after recall", int'(rdata_en), 1);
    end
    chk("R1 line free during recall", int'(sb_pull), 0);
    cs_n = 1; oe_n = 1;

    // R2: vector table
    for (int i = 0; i < 8; i++) do_write(VEC[i][18:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) do_read(VEC[i][18:8], VEC[i][7:0], "R2 table");
    @(negedge clk); cs_n = 0; oe_n = 1; #1;
    chk("R2 released when oe_n high", int'(rdata_en), 0);
    oe_n = 0; wr_n = 0; addr = VEC[0][18:8]; wdata = VEC[0][7:0]; #1;
    chk("R2 released while writing", int'(rdata_en), 0);
    @(negedge clk); cs_n = 1; oe_n = 1; wr_n = 1;

    // R3, R4, R5, R11: hardware store
    @(negedge clk); ext_low = 1;
    @(negedge clk); chk("R3 no pull before request width", int'(sb_pull), 0);
    @(negedge clk); chk("R3 pull at request", int'(sb_pull), 1);
    ext_low = 0; cs_n = 0; oe_n = 0;
    repeat (5) begin @(negedge clk); chk("R4 blocked during store", int'(rdata_en), 0); end
    ext_low = 1;
    repeat (3) begin @(negedge clk); chk("R11 busy holds", int'(sb_pull), 1); end
    ext_low = 0;
    n = 9;
    count_busy(n);
    chk("R4 busy window length", n, PULSE + STORE);
    chk("R5 blocked in recovery", int'(rdata_en), 0);
    repeat (RECOV - 1) begin @(negedge clk); chk("R5 blocked in recovery", int'(rdata_en), 0); end
    @(negedge clk); chk("R5 access reopens", int'(rdata_en), 1);
    cs_n = 1; oe_n = 1;
    repeat (8) begin @(negedge clk); chk("R11 no second store", int'(sb_pull), 0); end

    // R10 and R9: request during access, lock after store
    @(negedge clk); addr = A_ADR; wdata = 8'hD1; cs_n = 0; wr_n = 0; ext_low = 1;
    @(negedge clk);
    @(negedge clk); ext_low = 0;
    repeat (DRAIN - 1) @(negedge clk);
    chk("R10 pull deferred", int'(sb_pull), 0);
    @(negedge clk); chk("R10 pull after drain", int'(sb_pull), 1);
    wdata = 8'hD2;
    n = 1;
    count_busy(n);
    repeat (RECOV + 4) @(negedge clk);
    cs_n = 1; wr_n = 1;
    do_read(A_ADR, 8'hD1, "R9 held write locked after store");
    do_write(A_ADR, 8'hD2);
    do_read(A_ADR, 8'hD2, "R9 fresh edge unlocks");

    // R6, R7: automatic store
    do_write(B_ADR, 8'hE1);
    @(negedge clk); pwr_low = 1;
    @(negedge clk); chk("R6 auto store starts", int'(sb_pull), 1);
    n = 1;
    count_busy(n);
    chk("R6 auto busy window", n, PULSE + STORE);
    do_write(B_ADR, 8'hE2);
    do_read(B_ADR, 8'hE1, "R7 write refused while low");
    @(negedge clk); ext_low = 1;
    repeat (3) @(negedge clk);
    ext_low = 0;
    repeat (6) begin @(negedge clk); chk("R7 R6 no store while low", int'(sb_pull), 0); end
    pwr_low = 0;
    repeat (3) @(negedge clk);

    // R8: aborted automatic store
    do_write(B_ADR, 8'hE9);
    @(negedge clk); stuck_hi = 1; pwr_low = 1;
    @(negedge clk); chk("R8 attempt pulls", int'(sb_pull), 1);
    n = 1;
    count_busy(n);
    chk("R8 abort after pulse", n, PULSE);
    repeat (6) begin @(negedge clk); chk("R8 no retry", int'(sb_pull), 0); end
    stuck_hi = 0; pwr_low = 0;
    repeat (3) @(negedge clk);

    // R1, R9, R8, R4: power cycle with write held
    @(negedge clk); addr = A_ADR; wdata = 8'hFF; cs_n = 0; wr_n = 0; rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (RECALL + 3) @(negedge clk);
    cs_n = 1; wr_n = 1;
    do_read(A_ADR, 8'hD2, "R9 held write locked after recall");
    do_read(B_ADR, 8'hE1, "R8 R1 shadow kept after abort");
    for (int i = 0; i < 8; i++) do_read(VEC[i][18:8], VEC[i][7:0], "R1 R4 recalled table");
    do_write(A_ADR, 8'h77);
    do_read(A_ADR, 8'h77, "R9 edge unlocks after recall");

    finish_run();
  end
endmodule